// File: doc/BRIEF.md
# Register-Conditioned Branch Resolver

This unit settles conditional control transfers for a 32-bit processor core. The condition is judged on the value of a general register (zero, nonzero, sign bit clear, sign bit set, plus unconditional and never) rather than on a flag word. The destination is either the PC plus a sign-extended displacement from the instruction, or a 32-bit address taken from a second register.

An optional link write stores the PC value into a destination register as part of the same transfer, which is how a call saves its return point. The PC presented on `in_pc` is the value already advanced past the branch instruction. That same value is the fall-through address and the value saved by a link.

All results are registered. They appear on the clock edge after `in_valid`, with a single-cycle `out_done` pulse. The register file and instruction fetch sit outside the block: it receives the operand values and returns a write request.

Top module: `branch_resolver`

## Requirements
- R1: Condition code 3'b000 is never taken, 3'b001 is always taken, and the unused codes 3'b110 and 3'b111 are never taken.
- R2: Code 3'b010 is taken exactly when the tested value `in_test_val` equals zero.
- R3: Code 3'b011 is taken exactly when `in_test_val` is not zero.
- R4: Code 3'b100 is taken when bit XLEN-1 of `in_test_val` is 0, and code 3'b101 is taken when that bit is 1.
- R5: With `in_reg_tgt` = 0, a taken transfer sets `out_next_pc` to `in_pc` plus the displacement, modulo 2^XLEN.
- R6: The displacement `in_disp` is a two's-complement value sign-extended from bit DISP_W-1 before the addition.
- R7: With `in_reg_tgt` = 1, a taken transfer sets `out_next_pc` to `in_tgt_val`. The displacement has no effect.
- R8: A transfer that is not taken sets `out_next_pc` to `in_pc`.
- R9: When `in_link_en` = 1 and the index is nonzero, the result cycle raises `out_link_we` and presents `out_link_idx` = `in_link_idx` and `out_link_data` = `in_pc`. This happens whether or not the branch is taken.
- R10: No link write is raised when `in_link_idx` is 0 or `in_link_en` is 0.
- R11: `out_done` is high for exactly the cycle after each cycle with `in_valid` high. With `in_valid` low, `out_done` and `out_link_we` are low, and `out_taken` and `out_next_pc` hold their last values.
- R12: While `rst` is high and after it, until the first request, `out_done`, `out_taken`, `out_link_we`, `out_next_pc`, `out_link_idx` and `out_link_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_cond | input | 3 | Condition code |
| in_reg_tgt | input | 1 | 1: target from register, 0: PC-relative |
| in_test_val | input | XLEN | Value of the register under test |
| in_pc | input | XLEN | Already-incremented PC |
| in_disp | input | DISP_W | Two's-complement displacement |
| in_tgt_val | input | XLEN | Register-held target address |
| in_link_en | input | 1 | Request a link write |
| in_link_idx | input | IDX_W | Destination register index for the link |
| out_done | output | 1 | One-cycle result pulse |
| out_taken | output | 1 | Transfer taken |
| out_next_pc | output | XLEN | Next PC |
| out_link_we | output | 1 | Link write enable |
| out_link_idx | output | IDX_W | Link destination index |
| out_link_data | output | XLEN | Value to write (the PC) |

## Verification
The bench uses the default parameters: XLEN = 32, DISP_W = 16 and IDX_W = 5. With these widths, a 16-bit displacement reaches both sign polarities, and random PCs near the top or bottom of the 32-bit space make the relative sum wrap in both directions. Tested values are biased toward zero, the two sign boundaries and all ones, so that every condition code both hits and misses. Register index 0 is drawn often enough to exercise the link suppression.

// File: rtl/brres_pkg.sv
package brres_pkg;

    typedef enum logic [2:0] {
        BC_NEVER   = 3'b000,
        BC_ALWAYS  = 3'b001,
        BC_ZERO    = 3'b010,
        BC_NONZERO = 3'b011,
        BC_NONNEG  = 3'b100,
        BC_NEG     = 3'b101
    } bcond_e;

    localparam int COND_W = 3;

    // Decide a condition from two summary bits of the tested register.
    function automatic logic cond_hit(input logic [COND_W-1:0] code,
                                      input logic is_zero,
                                      input logic is_neg);
        logic hit;
        case (code)
            BC_ALWAYS:  hit = 1'b1;
            BC_ZERO:    hit = is_zero;
            BC_NONZERO: hit = !is_zero;
            BC_NONNEG:  hit = !is_neg;
            BC_NEG:     hit = is_neg;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/brres_cond_eval.sv
module brres_cond_eval #(
    parameter int XLEN = 32
) (
    input  logic [brres_pkg::COND_W-1:0] cond,
    input  logic [XLEN-1:0]              test_val,
    output logic                         taken
);
    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero = (test_val == '0);
        is_neg  = test_val[XLEN-1];
        taken   = brres_pkg::cond_hit(cond, is_zero, is_neg);
    end
endmodule

// File: rtl/brres_target_sel.sv
module brres_target_sel #(
    parameter int XLEN   = 32,
    parameter int DISP_W = 16
) (
    input  logic              taken,
    input  logic              use_reg,
    input  logic [XLEN-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   tgt_val,
    output logic [XLEN-1:0]   next_pc
);
    localparam int PAD_W = (XLEN > DISP_W) ? (XLEN - DISP_W) : 0;

    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] rel_tgt;

    generate
        if (PAD_W > 0) begin : g_pad
            assign disp_ext = {{PAD_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[XLEN-1:0];
        end
    endgenerate

    always_comb begin
        rel_tgt = pc + disp_ext;
        if (!taken)
            next_pc = pc;
        else if (use_reg)
            next_pc = tgt_val;
        else
            next_pc = rel_tgt;
    end
endmodule

// File: rtl/brres_link_gen.sv
module brres_link_gen #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input  logic             link_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  pc,
    output logic             we,
    output logic [IDX_W-1:0] idx_o,
    output logic [XLEN-1:0]  data
);
    always_comb begin
        we    = link_en && (idx != '0);
        idx_o = idx;
        data  = pc;
    end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver #(
    parameter int XLEN   = 32,
    parameter int DISP_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [brres_pkg::COND_W-1:0] in_cond,
    input  logic                         in_reg_tgt,
    input  logic [XLEN-1:0]              in_test_val,
    input  logic [XLEN-1:0]              in_pc,
    input  logic [DISP_W-1:0]            in_disp,
    input  logic [XLEN-1:0]              in_tgt_val,
    input  logic                         in_link_en,
    input  logic [IDX_W-1:0]             in_link_idx,
    output logic                         out_done,
    output logic                         out_taken,
    output logic [XLEN-1:0]              out_next_pc,
    output logic                         out_link_we,
    output logic [IDX_W-1:0]             out_link_idx,
    output logic [XLEN-1:0]              out_link_data
);
    typedef struct packed {
        logic            taken;
        logic [XLEN-1:0] npc;
    } xfer_t;

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  data;
    } link_t;

    logic  hit;
    xfer_t xfer_d, xfer_q;
    link_t link_d, link_q;
    logic  done_q;

    brres_cond_eval #(.XLEN(XLEN)) u_cond (
        .cond     (in_cond),
        .test_val (in_test_val),
        .taken    (hit)
    );

    brres_target_sel #(.XLEN(XLEN), .DISP_W(DISP_W)) u_tgt (
        .taken   (hit),
        .use_reg (in_reg_tgt),
        .pc      (in_pc),
        .disp    (in_disp),
        .tgt_val (in_tgt_val),
        .next_pc (xfer_d.npc)
    );

    brres_link_gen #(.XLEN(XLEN), .IDX_W(IDX_W)) u_link (
        .link_en (in_link_en),
        .idx     (in_link_idx),
        .pc      (in_pc),
        .we      (link_d.we),
        .idx_o   (link_d.idx),
        .data    (link_d.data)
    );

    assign xfer_d.taken = hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            xfer_q <= '0;
            link_q <= '0;
        end else begin
            done_q    <= in_valid;
            link_q.we <= in_valid && link_d.we;
            if (in_valid) begin
                xfer_q      <= xfer_d;
                link_q.idx  <= link_d.idx;
                link_q.data <= link_d.data;
            end
        end
    end

    assign out_done      = done_q;
    assign out_taken     = xfer_q.taken;
    assign out_next_pc   = xfer_q.npc;
    assign out_link_we   = link_q.we;
    assign out_link_idx  = link_q.idx;
    assign out_link_data = link_q.data;
endmodule

// File: rtl/brres_checker.sv
module brres_checker #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_valid,
    input logic [brres_pkg::COND_W-1:0] in_cond,
    input logic [XLEN-1:0]              in_pc,
    input logic                         in_link_en,
    input logic [IDX_W-1:0]             in_link_idx,
    input logic                         out_done,
    input logic                         out_taken,
    input logic [XLEN-1:0]              out_next_pc,
    input logic                         out_link_we,
    input logic [IDX_W-1:0]             out_link_idx,
    input logic [XLEN-1:0]              out_link_data
);
    // R11
    done_follows_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_done == ($past(in_valid) && !$past(rst)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_next_pc) && $stable(out_taken) && !out_link_we));

    // R1
    never_code_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cond == 3'b000) |=> !out_taken);

    // R1
    always_code_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cond == 3'b001) |=> out_taken);

    // R8
    fallthrough_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rst) |=> (out_taken || out_next_pc == $past(in_pc)));

    // R10
    no_zero_link_chk: assert property (@(posedge clk) disable iff (rst)
        out_link_we |-> (out_done && out_link_idx != '0));

    // R9
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_link_en && in_link_idx != '0) |=>
            (out_link_we && out_link_data == $past(in_pc) && out_link_idx == $past(in_link_idx)));
endmodule

bind branch_resolver brres_checker #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_cond       (in_cond),
    .in_pc         (in_pc),
    .in_link_en    (in_link_en),
    .in_link_idx   (in_link_idx),
    .out_done      (out_done),
    .out_taken     (out_taken),
    .out_next_pc   (out_next_pc),
    .out_link_we   (out_link_we),
    .out_link_idx  (out_link_idx),
    .out_link_data (out_link_data)
);

// File: tb/branch_resolver_tb.sv
module branch_resolver_tb;
    localparam int XLEN   = 32;
    localparam int DISP_W = 16;
    localparam int IDX_W  = 5;
    localparam int NRAND  = 3000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [2:0]        in_cond = '0;
    logic              in_reg_tgt = 1'b0;
    logic [XLEN-1:0]   in_test_val = '0;
    logic [XLEN-1:0]   in_pc = '0;
    logic [DISP_W-1:0] in_disp = '0;
    logic [XLEN-1:0]   in_tgt_val = '0;
    logic              in_link_en = 1'b0;
    logic [IDX_W-1:0]  in_link_idx = '0;
    logic              out_done, out_taken, out_link_we;
    logic [XLEN-1:0]   out_next_pc, out_link_data;
    logic [IDX_W-1:0]  out_link_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    branch_resolver #(.XLEN(XLEN), .DISP_W(DISP_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cond(in_cond),
        .in_reg_tgt(in_reg_tgt), .in_test_val(in_test_val), .in_pc(in_pc),
        .in_disp(in_disp), .in_tgt_val(in_tgt_val), .in_link_en(in_link_en),
        .in_link_idx(in_link_idx), .out_done(out_done), .out_taken(out_taken),
        .out_next_pc(out_next_pc), .out_link_we(out_link_we),
        .out_link_idx(out_link_idx), .out_link_data(out_link_data)
    );

    function automatic bit ref_taken(input logic [2:0] c, input logic [XLEN-1:0] v);
        logic signed [XLEN-1:0] sv = v;
        case (c)
            3'd1:    return 1'b1;
            3'd2:    return v == 0;
            3'd3:    return v != 0;
            3'd4:    return sv >= 0;
            3'd5:    return sv < 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] ref_npc(input bit tk, input bit rg,
            input logic [XLEN-1:0] pc, input logic [DISP_W-1:0] d, input logic [XLEN-1:0] t);
        logic signed [DISP_W-1:0] sd = d;
        if (!tk) return pc;
        if (rg)  return t;
        return pc + XLEN'(sd);
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] c, input bit rg, input logic [XLEN-1:0] tv,
            input logic [XLEN-1:0] pc, input logic [DISP_W-1:0] d, input logic [XLEN-1:0] t,
            input bit le, input logic [IDX_W-1:0] li, input string req);
        bit tk;
        bit we;
        @(negedge clk);
        in_valid = 1'b1; in_cond = c; in_reg_tgt = rg; in_test_val = tv; in_pc = pc;
        in_disp = d; in_tgt_val = t; in_link_en = le; in_link_idx = li;
        tk = ref_taken(c, tv);
        we = le && (li != 0);
        @(posedge clk); #1;
        chk({req, " R11 done"}, XLEN'(out_done), 1);
        chk({req, " taken"}, XLEN'(out_taken), XLEN'(tk));
        chk({req, " next_pc"}, out_next_pc, ref_npc(tk, rg, pc, d, t));
        chk("R9/R10 link_we", XLEN'(out_link_we), XLEN'(we));
        if (we) begin
            chk("R9 link_data", out_link_data, pc);
            chk("R9 link_idx", XLEN'(out_link_idx), XLEN'(li));
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [XLEN-1:0] hold_pc;
        logic            hold_tk;
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        chk("R12 done", XLEN'(out_done), 0);
        chk("R12 taken", XLEN'(out_taken), 0);
        chk("R12 next_pc", out_next_pc, 0);
        chk("R12 link_we", XLEN'(out_link_we), 0);
        chk("R12 link_data", out_link_data, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R12 done after release", XLEN'(out_done), 0);
        chk("R12 next_pc after release", out_next_pc, 0);

        // Directed corners
        apply(3'd0, 0, 32'h0, 32'h100, 16'h0010, 32'h0, 0, 5'd3, "R1 never");
        apply(3'd1, 0, 32'h0, 32'h100, 16'h0010, 32'h0, 0, 5'd3, "R1 always");
        apply(3'd6, 0, 32'h0, 32'h100, 16'h0010, 32'h0, 0, 5'd3, "R1 code6");
        apply(3'd7, 1, 32'h0, 32'h100, 16'h0010, 32'hABCD, 0, 5'd3, "R1 code7");
        apply(3'd2, 0, 32'h0, 32'h200, 16'h0020, 32'h0, 0, 5'd0, "R2 zero hit");
        apply(3'd2, 0, 32'h1, 32'h200, 16'h0020, 32'h0, 0, 5'd0, "R2 zero miss");
        apply(3'd3, 0, 32'h80000000, 32'h200, 16'h0020, 32'h0, 0, 5'd0, "R3 nonzero hit");
        apply(3'd3, 0, 32'h0, 32'h200, 16'h0020, 32'h0, 0, 5'd0, "R3 nonzero miss");
        apply(3'd4, 0, 32'h7FFFFFFF, 32'h300, 16'h0004, 32'h0, 0, 5'd0, "R4 nonneg max");
        apply(3'd4, 0, 32'h80000000, 32'h300, 16'h0004, 32'h0, 0, 5'd0, "R4 nonneg miss");
        apply(3'd5, 0, 32'hFFFFFFFF, 32'h300, 16'h0004, 32'h0, 0, 5'd0, "R4 neg hit");
        apply(3'd5, 0, 32'h0, 32'h300, 16'h0004, 32'h0, 0, 5'd0, "R4 neg miss");
        apply(3'd1, 0, 32'h0, 32'h1000, 16'h8000, 32'h0, 0, 5'd0, "R6 most negative disp");
        apply(3'd1, 0, 32'h0, 32'h1000, 16'h7FFF, 32'h0, 0, 5'd0, "R6 most positive disp");
        apply(3'd1, 0, 32'h0, 32'h00000004, 16'hFFF0, 32'h0, 0, 5'd0, "R5 wrap below zero");
        apply(3'd1, 0, 32'h0, 32'hFFFFFFF0, 16'h0020, 32'h0, 0, 5'd0, "R5 wrap above top");
        apply(3'd1, 1, 32'h0, 32'h1000, 16'h8000, 32'hDEAD0000, 0, 5'd0, "R7 register target");
        apply(3'd2, 1, 32'h5, 32'h1000, 16'h0040, 32'hDEAD0000, 1, 5'd31, "R8 not taken with link");
        apply(3'd1, 1, 32'h0, 32'h2468, 16'h0, 32'h4000, 1, 5'd31, "R9 call");
        apply(3'd1, 1, 32'h0, 32'h2468, 16'h0, 32'h4000, 1, 5'd0, "R10 index zero");
        apply(3'd1, 1, 32'h0, 32'h2468, 16'h0, 32'h4000, 0, 5'd7, "R10 link disabled");

        // Idle cycle: results hold, no pulses (R11)
        hold_pc = out_next_pc;
        hold_tk = out_taken;
        @(negedge clk);
        in_valid = 1'b0; in_cond = 3'd1; in_reg_tgt = 1'b1; in_tgt_val = 32'h13579BDF;
        in_link_en = 1'b1; in_link_idx = 5'd9;
        @(posedge clk); #1;
        chk("R11 idle done", XLEN'(out_done), 0);
        chk("R11 idle link_we", XLEN'(out_link_we), 0);
        chk("R11 idle next_pc", out_next_pc, hold_pc);
        chk("R11 idle taken", XLEN'(out_taken), XLEN'(hold_tk));

        // Constrained random, back to back
        for (int i = 0; i < NRAND; i++) begin
            logic [XLEN-1:0] tv;
            logic [XLEN-1:0] pc;
            case ($urandom_range(0, 5))
                0: tv = '0;
                1: tv = 32'h80000000;
                2: tv = 32'h7FFFFFFF;
                3: tv = '1;
                default: tv = $urandom;
            endcase
            case ($urandom_range(0, 3))
                0: pc = 32'hFFFF0000 | 32'($urandom_range(0, 16'hFFFF));
                1: pc = 32'($urandom_range(0, 16'hFFFF));
                default: pc = $urandom;
            endcase
            apply(3'($urandom_range(0, 7)), 1'($urandom), tv, pc, DISP_W'($urandom),
                  $urandom, 1'($urandom), ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom),
                  "R2/R3/R4/R5/R7 random");
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        chk("R11 done drops", XLEN'(out_done), 0);
        finish_run();
    end
endmodule